// File: doc/BRIEF.md
# Event-Synchronised Chained DMA Engine

This block is a single-channel DMA engine that runs a circular chain of transfer descriptors kept in a small internal table. Software fills the table through a write-only configuration port. Each entry holds a source address, a destination address, a word count, a flag that makes it wait for an external event, a flag that raises an interrupt when it finishes, and the index of the entry that follows it. Once the run input goes high, the engine starts at entry 0. It reads each word over a request/response read port and writes it to a destination port. It then follows the link indices without further help from software.

The typical use is capturing a sampled frame split into two banks. An entry that waits for an event moves the first word of a bank. An entry that does not wait moves the rest of that bank. Four entries linked in a ring store 32 channels contiguously per loop, and only the last entry is flagged for an interrupt. Software therefore gets one interrupt per complete frame.

Top module: `evsync_dma`

## Requirements
- R1: After an entry completes, the engine loads the entry named by its link index. A ring of four entries (0→1→2→3→0) repeats indefinitely without software reprogramming it.
- R2: An entry with the sync flag set moves no data until an event is available. It then moves exactly its programmed word count, and the engine stalls again at the next synced entry.
- R3: An entry with the sync flag clear starts its reads right after the previous entry completes, with no event needed.
- R4: Within an entry, the source and destination addresses start at the programmed values and rise by one per word. Each written word equals the word read from the matching source address.
- R5: The irq output is high for exactly one cycle when an entry with the interrupt flag completes. Entries without the flag never raise it.
- R6: An entry with a word count of zero completes without any bus access. It raises irq if flagged and then follows its link.
- R7: An event that arrives while the engine is not waiting is held in a one-deep pending flag, and a later synced entry consumes it. An event that arrives while the flag is already set sets the sticky overrun output. Starting the engine clears both the pending flag and overrun.
- R8: A high run input in the idle state starts execution at entry 0. Dropping run stops the engine once the word in flight has been written, and busy then reads 0.
- R9: A transfer happens when valid and ready are both high at a rising clock edge. A request is held with stable address (and data) until accepted. At most one read is outstanding, and no new read request follows an accepted one in the next cycle.
- R10: Configuration writes use cfg_field encodings 0 = source address, 1 = destination address and 2 = control word; encoding 3 is ignored. Control word bits [7:0] hold the count, bit 8 the sync flag, bit 9 the interrupt flag, and the link index starts at bit 10 (bits [11:10] with four entries).
- R11: After reset, rd_valid, wr_valid, irq, busy and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start (high) and stop (low) control |
| evt | input | 1 | External event pulse |
| cfg_we | input | 1 | Descriptor table write strobe |
| cfg_idx | input | IDX_W | Descriptor entry being written |
| cfg_field | input | 2 | Field select: 0 source, 1 destination, 2 control |
| cfg_data | input | ADDR_W | Write data |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Read request address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | DATA_W | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_ready | input | 1 | Write request accepted |
| irq | output | 1 | One-cycle completion interrupt |
| busy | output | 1 | Engine is not idle |
| overrun | output | 1 | Sticky event overrun status |

## Verification
The hardest situation to reach is the pending and overrun path. It needs events to arrive while the engine is in the middle of an unsynced burst, so it is not waiting. The stimulus fires one event to release entry 0, then fires two more while entry 1 is still copying its 15 words. It then checks three things: the second synced entry runs with no further event, overrun is set, and the chain then stalls at entry 0. Read and write backpressure during a wrap-around frame, a zero-count flagged entry, and a stop in the middle of a long burst cover the remaining corner cases.

// File: rtl/evdma_pkg.sv
package evdma_pkg;

    // Control word layout, shared by the configuration port and the table
    localparam int CNT_W    = 8;
    localparam int SYNC_BIT = CNT_W;
    localparam int IRQ_BIT  = CNT_W + 1;
    localparam int LINK_LSB = CNT_W + 2;

    typedef logic [CNT_W-1:0] count_t;

    // Packed so that {irq, sync, cnt} lines up with control word bits [IRQ_BIT:0]
    typedef struct packed {
        logic   irq;
        logic   sync;
        count_t cnt;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CTRL = 2'd2
    } cfg_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_RREQ,
        ST_RRSP,
        ST_WRITE,
        ST_DONE
    } eng_state_e;

    function automatic ctrl_t decode_ctrl(input logic [IRQ_BIT:0] bits);
        return ctrl_t'(bits);
    endfunction

endpackage

// File: rtl/evdma_desc_table.sv
module evdma_desc_table
    import evdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NDESC  = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_dst,
    output ctrl_t             rd_ctrl,
    output logic [IDX_W-1:0]  rd_link
);

    logic [ADDR_W-1:0] src_a  [NDESC];
    logic [ADDR_W-1:0] dst_a  [NDESC];
    ctrl_t             ctrl_a [NDESC];
    logic [IDX_W-1:0]  link_a [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_ent
        logic [ADDR_W-1:0] src_q;
        logic [ADDR_W-1:0] dst_q;
        ctrl_t             ctrl_q;
        logic [IDX_W-1:0]  link_q;

        // R10: field select 0/1/2, select 3 leaves the entry untouched
        always_ff @(posedge clk) begin
            if (rst) begin
                src_q  <= '0;
                dst_q  <= '0;
                ctrl_q <= '0;
                link_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                case (cfg_sel_e'(wr_sel))
                    SEL_SRC:  src_q <= wr_data;
                    SEL_DST:  dst_q <= wr_data;
                    SEL_CTRL: begin
                        ctrl_q <= decode_ctrl(wr_data[IRQ_BIT:0]);
                        link_q <= wr_data[LINK_LSB +: IDX_W];
                    end
                    default: ;
                endcase
            end
        end

        assign src_a[g]  = src_q;
        assign dst_a[g]  = dst_q;
        assign ctrl_a[g] = ctrl_q;
        assign link_a[g] = link_q;
    end

    assign rd_src  = src_a[rd_idx];
    assign rd_dst  = dst_a[rd_idx];
    assign rd_ctrl = ctrl_a[rd_idx];
    assign rd_link = link_a[rd_idx];

endmodule

// File: rtl/evdma_evt_latch.sv
module evdma_evt_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic evt,
    input  logic consume,
    output logic avail,
    output logic overrun
);

    logic pend_q;
    logic ovr_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (consume) begin
            // one event used; a simultaneous second one stays pending
            pend_q <= pend_q && evt;
        end else if (evt) begin
            if (pend_q) ovr_q <= 1'b1;
            pend_q <= 1'b1;
        end
    end

    assign avail   = pend_q || evt;
    assign overrun = ovr_q;

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(pend_q && evt && !consume)) else $error("overrun without a second event"); // R7

    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (consume && !evt) |=> !pend_q) else $error("pending flag kept after use"); // R7

endmodule

// File: rtl/evdma_engine.sv
module evdma_engine
    import evdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [ADDR_W-1:0] d_src,
    input  logic [ADDR_W-1:0] d_dst,
    input  ctrl_t             d_ctrl,
    input  logic [IDX_W-1:0]  d_link,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic              evt_avail,
    output logic              evt_consume,
    output logic              start_clr,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              irq,
    output logic              busy
);

    eng_state_e        st_q, st_n;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  link_q;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [DATA_W-1:0] data_q;
    count_t            rem_q;
    logic              irqf_q;

    always_comb begin
        st_n = st_q;
        case (st_q)
            ST_IDLE:  if (run) st_n = ST_LOAD;
            ST_LOAD: begin
                if (!run)                     st_n = ST_IDLE;
                else if (d_ctrl.sync)         st_n = ST_WAIT;
                else if (d_ctrl.cnt == '0)    st_n = ST_DONE;
                else                          st_n = ST_RREQ;
            end
            ST_WAIT: begin
                if (!run)           st_n = ST_IDLE;
                else if (evt_avail) st_n = (rem_q == '0) ? ST_DONE : ST_RREQ;
            end
            ST_RREQ:  if (rd_ready)  st_n = ST_RRSP;
            ST_RRSP:  if (rsp_valid) st_n = ST_WRITE;
            ST_WRITE: begin
                if (wr_ready) begin
                    if (rem_q == count_t'(1)) st_n = ST_DONE;
                    else if (!run)            st_n = ST_IDLE;
                    else                      st_n = ST_RREQ;
                end
            end
            ST_DONE:  st_n = run ? ST_LOAD : ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            link_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            data_q <= '0;
            rem_q  <= '0;
            irqf_q <= 1'b0;
        end else begin
            st_q <= st_n;
            case (st_q)
                ST_IDLE: if (run) idx_q <= '0;
                ST_LOAD: begin
                    src_q  <= d_src;
                    dst_q  <= d_dst;
                    rem_q  <= d_ctrl.cnt;
                    irqf_q <= d_ctrl.irq;
                    link_q <= d_link;
                end
                ST_RRSP: if (rsp_valid) data_q <= rsp_data;
                ST_WRITE: begin
                    if (wr_ready) begin
                        src_q <= src_q + ADDR_W'(1);
                        dst_q <= dst_q + ADDR_W'(1);
                        rem_q <= rem_q - count_t'(1);
                    end
                end
                ST_DONE: idx_q <= link_q;
                default: ;
            endcase
        end
    end

    assign cur_idx     = idx_q;
    assign evt_consume = (st_q == ST_WAIT) && run && evt_avail;
    assign start_clr   = (st_q == ST_IDLE) && run;
    assign rd_valid    = (st_q == ST_RREQ);
    assign rd_addr     = src_q;
    assign wr_valid    = (st_q == ST_WRITE);
    assign wr_addr     = dst_q;
    assign wr_data     = data_q;
    assign irq         = (st_q == ST_DONE) && irqf_q;
    assign busy        = (st_q != ST_IDLE);

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))) else $error("read request dropped"); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))) else $error("write request changed"); // R9

    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> !rd_valid) else $error("second read outstanding"); // R9

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq) else $error("irq longer than one cycle"); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (rem_q != '0)) else $error("word count underflow"); // R2

endmodule

// File: rtl/evsync_dma.sv
module evsync_dma
    import evdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NDESC  = 4,
    localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              evt,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_field,
    input  logic [ADDR_W-1:0] cfg_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              irq,
    output logic              busy,
    output logic              overrun
);

    logic [IDX_W-1:0]  cur_idx;
    logic [ADDR_W-1:0] d_src;
    logic [ADDR_W-1:0] d_dst;
    ctrl_t             d_ctrl;
    logic [IDX_W-1:0]  d_link;
    logic              evt_avail;
    logic              evt_consume;
    logic              start_clr;

    evdma_desc_table #(.ADDR_W(ADDR_W), .NDESC(NDESC), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_sel  (cfg_field),
        .wr_data (cfg_data),
        .rd_idx  (cur_idx),
        .rd_src  (d_src),
        .rd_dst  (d_dst),
        .rd_ctrl (d_ctrl),
        .rd_link (d_link)
    );

    evdma_evt_latch u_evt (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_clr),
        .evt     (evt),
        .consume (evt_consume),
        .avail   (evt_avail),
        .overrun (overrun)
    );

    evdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .d_src       (d_src),
        .d_dst       (d_dst),
        .d_ctrl      (d_ctrl),
        .d_link      (d_link),
        .cur_idx     (cur_idx),
        .evt_avail   (evt_avail),
        .evt_consume (evt_consume),
        .start_clr   (start_clr),
        .rd_valid    (rd_valid),
        .rd_addr     (rd_addr),
        .rd_ready    (rd_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_ready    (wr_ready),
        .irq         (irq),
        .busy        (busy)
    );

endmodule

// File: tb/test_evsync_dma.sv
module test_evsync_dma;

    localparam logic [31:0] SRC_BASE = 32'h8020_0000;
    localparam logic [31:0] BUF      = 32'h0000_4000;

    typedef struct packed {
        logic [7:0] off;
        logic       sync;
        logic       irqf;
        logic [7:0] cnt;
        logic [1:0] link;
    } seg_t;

    // Standard two-bank capture ring; src and dst offsets coincide with the log position
    localparam seg_t STD_TBL [4] = '{
        '{8'h00, 1'b1, 1'b0, 8'd1,  2'd1},
        '{8'h01, 1'b0, 1'b0, 8'd15, 2'd2},
        '{8'h10, 1'b1, 1'b0, 8'd1,  2'd3},
        '{8'h11, 1'b0, 1'b1, 8'd15, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        evt = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [1:0]  cfg_field = '0;
    logic [31:0] cfg_data = '0;
    logic        rd_valid;
    logic [31:0] rd_addr;
    logic        rd_ready = 1'b1;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        irq;
    logic        busy;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    int wcnt = 0, rcnt = 0, irq_cnt = 0, irq_rise = 0;
    int cyc = 0;
    bit bp = 1'b0;
    bit done = 1'b0;
    bit irq_q = 1'b0;
    logic [31:0] log_a [256];
    logic [31:0] log_d [256];

    evsync_dma i_evsync_dma (
        .clk(clk), .rst(rst), .run(run), .evt(evt),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_field(cfg_field), .cfg_data(cfg_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .irq(irq), .busy(busy), .overrun(overrun)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mdat(input logic [31:0] a);
        return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic cfg_wr(input int idx, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx[1:0]; cfg_field = sel; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: control word = {link at bit 10, irq bit 9, sync bit 8, count [7:0]}
    task automatic prog(input int idx, input logic [31:0] s, input logic [31:0] d,
                        input logic [7:0] cnt, input logic sy, input logic iq, input logic [1:0] lk);
        cfg_wr(idx, 2'd0, s);
        cfg_wr(idx, 2'd1, d);
        cfg_wr(idx, 2'd2, {20'b0, lk, iq, sy, cnt});
    endtask

    task automatic pulse();
        @(negedge clk); evt = 1'b1;
        @(negedge clk); evt = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_frame(input int base, input string req);
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < int'(STD_TBL[s].cnt); k++) begin
                int p = base + int'(STD_TBL[s].off) + k;
                chk(req, log_a[p], BUF + 32'(STD_TBL[s].off) + 32'(k));
                chk(req, log_d[p], mdat(SRC_BASE + 32'(STD_TBL[s].off) + 32'(k)));
            end
        end
    endtask

    // Ready generation, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rd_ready = bp ? ((cyc % 3) != 0) : 1'b1;
            wr_ready = bp ? ((cyc % 2) == 0) : 1'b1;
        end
    end

    // Source responder and destination logger
    initial begin
        forever begin
            @(posedge clk);
            rsp_valid <= rd_valid && rd_ready && !rst;
            rsp_data  <= mdat(rd_addr);
            if (!rst) begin
                if (rd_valid && rd_ready) rcnt++;
                if (wr_valid && wr_ready) begin
                    if (wcnt < 256) begin
                        log_a[wcnt] = wr_addr;
                        log_d[wcnt] = wr_data;
                    end
                    wcnt++;
                end
                if (irq) irq_cnt++;
                if (irq && !irq_q) irq_rise++;
                irq_q = irq;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int w0, w1, i0;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R11 reset state
        chk("R11 rd_valid", 32'(rd_valid), 0);
        chk("R11 wr_valid", 32'(wr_valid), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 busy", 32'(busy), 0);
        chk("R11 overrun", 32'(overrun), 0);

        // Program the ring from the vector table (R10 encodings)
        for (int s = 0; s < 4; s++)
            prog(s, SRC_BASE + 32'(STD_TBL[s].off), BUF + 32'(STD_TBL[s].off),
                 STD_TBL[s].cnt, STD_TBL[s].sync, STD_TBL[s].irqf, STD_TBL[s].link);

        run = 1'b1;
        wait_cyc(40);
        chk("R2 stall before event", 32'(wcnt), 0);
        chk("R8 busy after start", 32'(busy), 1);

        pulse();
        wait_cyc(120);
        chk("R3 first bank words", 32'(wcnt), 16);
        chk("R2 stall at second synced entry", 32'(wcnt), 16);
        chk("R5 no irq mid-frame", 32'(irq_cnt), 0);

        pulse();
        wait_cyc(120);
        chk("R1 full frame words", 32'(wcnt), 32);
        chk("R5 one irq per frame", 32'(irq_cnt), 1);
        check_frame(0, "R4 frame data");

        // Wrap-around frame under backpressure
        bp = 1'b1;
        pulse();
        wait_cyc(250);
        pulse();
        wait_cyc(250);
        bp = 1'b0;
        chk("R1 second loop words", 32'(wcnt), 64);
        chk("R5 irq second loop", 32'(irq_cnt), 2);
        check_frame(32, "R1 second loop data");
        chk("R9 reads equal writes", 32'(rcnt), 32'(wcnt));

        // Pending and overrun
        pulse();
        wait_cyc(6);
        pulse();
        wait_cyc(3);
        pulse();
        wait_cyc(200);
        chk("R7 pending releases second bank", 32'(wcnt), 96);
        chk("R7 overrun set", 32'(overrun), 1);
        chk("R5 irq third loop", 32'(irq_cnt), 3);
        check_frame(64, "R7 third loop data");
        wait_cyc(60);
        chk("R7 pending one deep", 32'(wcnt), 96);

        run = 1'b0;
        wait_cyc(5);
        chk("R8 idle after stop", 32'(busy), 0);
        run = 1'b1;
        wait_cyc(3);
        chk("R7 overrun cleared at start", 32'(overrun), 0);
        run = 1'b0;
        wait_cyc(5);

        // Stop in the middle of a long burst
        prog(0, SRC_BASE + 32'h40, BUF + 32'h100, 8'd200, 1'b0, 1'b0, 2'd0);
        w0 = wcnt;
        run = 1'b1;
        wait_cyc(30);
        chk("R8 restart at entry 0", log_a[w0], BUF + 32'h100);
        chk("R4 burst data", log_d[w0 + 1], mdat(SRC_BASE + 32'h41));
        run = 1'b0;
        wait_cyc(20);
        w1 = wcnt;
        chk("R8 word in flight completed", 32'(rcnt), 32'(wcnt));
        chk("R8 busy low after stop", 32'(busy), 0);
        wait_cyc(20);
        chk("R8 no writes after stop", 32'(wcnt), 32'(w1));

        // Zero-count flagged entry
        prog(0, SRC_BASE, BUF, 8'd0, 1'b0, 1'b1, 2'd1);
        prog(1, SRC_BASE + 32'h80, BUF + 32'h200, 8'd2, 1'b0, 1'b0, 2'd2);
        prog(2, SRC_BASE, BUF, 8'd1, 1'b1, 1'b0, 2'd0);
        w0 = wcnt;
        i0 = irq_cnt;
        run = 1'b1;
        wait_cyc(40);
        chk("R6 irq on empty entry", 32'(irq_cnt), 32'(i0 + 1));
        chk("R6 link followed", 32'(wcnt), 32'(w0 + 2));
        chk("R6 next entry address", log_a[w0], BUF + 32'h200);
        chk("R4 address step", log_a[w0 + 1], BUF + 32'h201);
        chk("R4 data copy", log_d[w0 + 1], mdat(SRC_BASE + 32'h81));
        chk("R2 waiting at synced entry", 32'(busy), 1);
        chk("R5 irq one cycle each", 32'(irq_cnt), 32'(irq_rise));
        run = 1'b0;
        wait_cyc(5);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule